// File: doc/BRIEF.md
# Region Protection Translation Unit

This unit protects and translates addresses on a core that has no paged memory manager. The 4 GB address space is cut into eight fixed regions of 512 MB. Each region has one entry on the instruction side and one on the data side. An entry holds the top three bits of a physical base and a 4-bit attribute. A lookup is purely combinational. It takes a virtual address and an access type, and from them it produces the following results in the same cycle:

- the physical address;
- the read/write/execute permission mask;
- the page size;
- a fault flag with an exception cause.

Software rewrites entries through a single write port. A new entry value takes effect on the clock edge that captures the write.

An enable input chooses between the protected mode and a bypass mode. In bypass mode every address passes through unchanged, all permissions are granted, and no fault is raised.

Top module: `region_xlate_unit`

## Requirements
- R1: The region is chosen by virtual address bits [31:29]. Fetches (`acc_type` = 2) use the instruction-side entries. Loads (0), stores (1) and the reserved type (3) use the data-side entries.
- R2: `perm[0]` (read) and `perm[1]` (write) are both set when the attribute is below 6 and is not 3. They are also both set when the attribute equals 14. Otherwise both are clear.
- R3: `perm[2]` (execute) is set exactly when the attribute is in the range 1 to 5 inclusive.
- R4: The required permission depends on the access type: load needs read, store needs write, fetch needs execute, and type 3 is never granted. When the required permission is missing, `fault` is 1 and `cause` is 28 for a load, 29 for a store or type 3, and 20 for a fetch. When the access is granted, `fault` is 0 and `cause` is 0.
- R5: In protected mode, `pa` is {entry base, va[28:0]} and `page_size` is 0x2000_0000.
- R6: After reset, every entry on both sides maps its region to itself (base = region index) with attribute 2.
- R7: When `prot_en` is 0, `pa` equals `va`, `perm` is 3'b111, `fault` and `cause` are 0, and `page_size` is 4096.
- R8: A write (`wr_en`, `wr_side` 0 = instruction, 1 = data, `wr_idx`, `wr_base`, `wr_attr`) is seen by the first lookup after the capturing clock edge. It alters only the addressed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_en | input | 1 | 1 = protected mode, 0 = bypass |
| va | input | 32 | Virtual address |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | 0 instruction side, 1 data side |
| wr_idx | input | 3 | Entry index to write |
| wr_base | input | 3 | New physical base (address bits 31:29) |
| wr_attr | input | 4 | New attribute |
| pa | output | 32 | Physical address |
| perm | output | 3 | {execute, write, read} |
| page_size | output | 32 | Bytes per translation unit |
| fault | output | 1 | Access denied |
| cause | output | 6 | Exception cause when faulting, else 0 |

## Verification
Every lookup reads the stored entries directly, so a corrupted base shows up in the upper bits of `pa` in the same cycle. A corrupted attribute shows up at once in `perm`, and also in `fault`/`cause` for the access types that depend on it. A write that lands on the wrong side or the wrong index, or that lands late, is visible from the cycle after the capturing edge. Sweeping all sixteen entries after each directed write exposes it at that point. Mixing random writes and lookups against a reference model catches the remaining differences within a few lookups.

// File: rtl/region_xlate_unit.sv
module region_xlate_unit #(
  parameter int AW          = 32,
  parameter int IDX_W       = 3,
  parameter int ATTR_W      = 4,
  parameter int CAUSE_W     = 6,
  parameter int RESET_ATTR  = 2,
  parameter int BYPASS_PAGE = 4096,
  parameter int CAUSE_FETCH = 20,
  parameter int CAUSE_LOAD  = 28,
  parameter int CAUSE_STORE = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prot_en,
  input  logic [AW-1:0]      va,
  input  logic [1:0]         acc_type,
  input  logic               wr_en,
  input  logic               wr_side,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [IDX_W-1:0]   wr_base,
  input  logic [ATTR_W-1:0]  wr_attr,
  output logic [AW-1:0]      pa,
  output logic [2:0]         perm,
  output logic [AW-1:0]      page_size,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  localparam int N     = 1 << IDX_W;
  localparam int OFF_W = AW - IDX_W;

  logic [IDX_W-1:0]  ibase [N];
  logic [ATTR_W-1:0] iattr [N];
  logic [IDX_W-1:0]  dbase [N];
  logic [ATTR_W-1:0] dattr [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        ibase[i] <= IDX_W'(i);
        dbase[i] <= IDX_W'(i);
        iattr[i] <= ATTR_W'(RESET_ATTR);
        dattr[i] <= ATTR_W'(RESET_ATTR);
      end
    end else if (wr_en) begin
      if (wr_side) begin
        dbase[wr_idx] <= wr_base;
        dattr[wr_idx] <= wr_attr;
      end else begin
        ibase[wr_idx] <= wr_base;
        iattr[wr_idx] <= wr_attr;
      end
    end
  end

  wire              is_fetch = (acc_type == 2'd2);
  wire [IDX_W-1:0]  ridx     = va[AW-1 -: IDX_W];
  wire [IDX_W-1:0]  sel_base = is_fetch ? ibase[ridx] : dbase[ridx];
  wire [ATTR_W-1:0] sel_attr = is_fetch ? iattr[ridx] : dattr[ridx];

  wire rw_ok = ((sel_attr < ATTR_W'(6)) && (sel_attr != ATTR_W'(3))) ||
               (sel_attr == ATTR_W'(14));
  wire x_ok  = (sel_attr >= ATTR_W'(1)) && (sel_attr <= ATTR_W'(5));

  logic granted;
  always_comb begin
    case (acc_type)
      2'd0:    granted = rw_ok;
      2'd1:    granted = rw_ok;
      2'd2:    granted = x_ok;
      default: granted = 1'b0;
    endcase
  end

  logic [CAUSE_W-1:0] deny_cause;
  always_comb begin
    if (is_fetch)                deny_cause = CAUSE_W'(CAUSE_FETCH);
    else if (acc_type == 2'd0)   deny_cause = CAUSE_W'(CAUSE_LOAD);
    else                         deny_cause = CAUSE_W'(CAUSE_STORE);
  end

  assign pa        = prot_en ? {sel_base, va[OFF_W-1:0]} : va;
  assign perm      = prot_en ? {x_ok, rw_ok, rw_ok} : 3'b111;
  assign page_size = prot_en ? (AW'(1) << OFF_W) : AW'(BYPASS_PAGE);
  assign fault     = prot_en && !granted;
  assign cause     = fault ? deny_cause : '0;
endmodule

// File: rtl/region_xlate_unit_chk.sv
module region_xlate_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        prot_en,
  input logic [31:0] va,
  input logic [1:0]  acc_type,
  input logic        wr_en,
  input logic        wr_side,
  input logic [2:0]  wr_idx,
  input logic [2:0]  wr_base,
  input logic [31:0] pa,
  input logic [2:0]  perm,
  input logic [31:0] page_size,
  input logic        fault,
  input logic [5:0]  cause
);
  logic seen_clk;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_clk <= 1'b0;
    else        seen_clk <= 1'b1;

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    prot_en |-> (pa[28:0] == va[28:0] && page_size == 32'h2000_0000)); // R5
  AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |-> (pa == va && perm == 3'b111 && !fault && cause == 6'd0)); // R7
  AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    perm[1] |-> perm[0]); // R2
  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault |-> cause != 6'd0) and (!fault |-> cause == 6'd0)); // R4
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && $past(wr_en) && prot_en && va[31:29] == $past(wr_idx) &&
     ((acc_type == 2'd2) == !$past(wr_side))) |-> pa[31:29] == $past(wr_base)); // R8
endmodule

bind region_xlate_unit region_xlate_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .va(va), .acc_type(acc_type),
  .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx), .wr_base(wr_base),
  .pa(pa), .perm(perm), .page_size(page_size), .fault(fault), .cause(cause)
);

// File: tb/region_xlate_unit_bench.sv
module region_xlate_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_en = 1'b1;
  logic [31:0] va = '0;
  logic [1:0]  acc_type = '0;
  logic        wr_en = 1'b0;
  logic        wr_side = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [2:0]  wr_base = '0;
  logic [3:0]  wr_attr = '0;
  logic [31:0] pa;
  logic [2:0]  perm;
  logic [31:0] page_size;
  logic        fault;
  logic [5:0]  cause;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [2:0] m_base [2][8];
  logic [3:0] m_attr [2][8];

  region_xlate_unit u_region_xlate_unit (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .va(va), .acc_type(acc_type),
    .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx), .wr_base(wr_base),
    .wr_attr(wr_attr), .pa(pa), .perm(perm), .page_size(page_size),
    .fault(fault), .cause(cause)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] exp_perm(input logic [3:0] a);
    logic rw, x;
    rw = ((a < 6) && (a != 3)) || (a == 14);
    x  = (a >= 1) && (a <= 5);
    return {x, rw, rw};
  endfunction

  function automatic logic exp_ok(input logic [2:0] p, input logic [1:0] t);
    case (t)
      2'd0: return p[0];
      2'd1: return p[1];
      2'd2: return p[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [5:0] exp_cause(input logic [1:0] t);
    if (t == 2'd2) return 6'd20;
    if (t == 2'd0) return 6'd28;
    return 6'd29;
  endfunction

  task automatic lookup(input logic en, input logic [31:0] a, input logic [1:0] t, input string req);
    int side;
    logic [2:0] ep;
    logic [31:0] epa, eps;
    logic ef;
    logic [5:0] ec;
    prot_en = en; va = a; acc_type = t;
    #1;
    side = (t == 2'd2) ? 0 : 1;
    if (en) begin
      ep  = exp_perm(m_attr[side][a[31:29]]);
      epa = {m_base[side][a[31:29]], a[28:0]};
      eps = 32'h2000_0000;
      ef  = !exp_ok(ep, t);
      ec  = ef ? exp_cause(t) : 6'd0;
    end else begin
      ep = 3'b111; epa = a; eps = 32'd4096; ef = 1'b0; ec = 6'd0;
    end
    checks++;
    if (pa !== epa || perm !== ep || page_size !== eps || fault !== ef || cause !== ec) begin
      fails++;
      $display("FAIL %s va=%h t=%0d: pa=%h perm=%b size=%h fault=%b cause=%0d, expected pa=%h perm=%b size=%h fault=%b cause=%0d",
               req, a, t, pa, perm, page_size, fault, cause, epa, ep, eps, ef, ec);
    end
  endtask

  task automatic write_entry(input logic s, input logic [2:0] i, input logic [2:0] b, input logic [3:0] at);
    @(negedge clk);
    wr_en = 1'b1; wr_side = s; wr_idx = i; wr_base = b; wr_attr = at;
    @(negedge clk);
    wr_en = 1'b0;
    m_base[s][i] = b;
    m_attr[s][i] = at;
  endtask

  task automatic sweep(input string req);
    for (int r = 0; r < 8; r++) begin
      lookup(1'b1, {3'(r), 29'h0ABC_123}, 2'd0, req);
      lookup(1'b1, {3'(r), 29'h1555_0004}, 2'd2, req);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++) begin
        m_base[s][i] = 3'(i);
        m_attr[s][i] = 4'd2;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    sweep("R6 reset identity");
    lookup(1'b1, 32'hFFFF_FFFC, 2'd1, "R5 top region offset");
    lookup(1'b1, 32'h0000_0000, 2'd3, "R4 reserved type");

    for (int a = 0; a < 16; a++) begin
      write_entry(1'b1, 3'd1, 3'd6, 4'(a));
      write_entry(1'b0, 3'd1, 3'd3, 4'(a));
      lookup(1'b1, 32'h2000_0040, 2'd0, "R2 load attr");
      lookup(1'b1, 32'h3FFF_FFF0, 2'd1, "R2 R4 store attr");
      lookup(1'b1, 32'h2123_4567, 2'd2, "R3 R4 fetch attr");
      lookup(1'b1, 32'h2000_0008, 2'd3, "R4 reserved attr");
    end

    write_entry(1'b1, 3'd5, 3'd2, 4'd14);
    sweep("R8 R1 data write isolation");
    write_entry(1'b0, 3'd7, 3'd0, 4'd3);
    sweep("R8 R1 instr write isolation");

    for (int k = 0; k < 20; k++)
      lookup(1'b0, $urandom, 2'($urandom), "R7 bypass");

    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 3) == 0)
        write_entry(1'($urandom), 3'($urandom), 3'($urandom), 4'($urandom));
      lookup(($urandom_range(0, 9) != 0), $urandom, 2'($urandom), "R1 R5 random");
    end

    sweep("R8 final state");
    finish_run();
  end
endmodule